// File: doc/BRIEF.md
# Alarm Timer with Coherent Count Readout

The block keeps a free-running nanosecond count, two 32-bit halves wide, that advances by a fixed step on every clock. Software reads the count through a 32-bit register port. A read of the low half also copies the live high half into a holding register, and a later read of the high half returns that copy. A pair of reads, low half first, therefore always describes one instant, even when a carry crosses between the halves in between.

To schedule an event, software writes the upper alarm half and then the lower half. The lower write commits the full alarm value and arms the comparator. When the count is at or beyond the armed alarm, a pending flag sets and the comparator disarms, so each arming gives exactly one event. The level interrupt output is the pending flag gated by an enable bit. Software drops the pending flag with a clear write. Each alarm should lie between 1 and 2^32-1 ticks ahead of the count.

Top module: `alarm_timer`

## Requirements
- R1: After reset (rst_ni low) the count, the alarm, the staged upper alarm half, the armed flag, the pending flag, the enable bit and the high-half holding register are all zero; `irq_o` is low and `rdata_o` is zero.
- R2: While out of reset, the count grows by STEP (default 1) on every clock edge. It is 2*HALF_W bits wide and wraps modulo 2^(2*HALF_W).
- R3: A read (`rd_en_i` high) of offset 0x000 returns, on `rdata_o` one clock later, the low HALF_W bits of the count as it stood at that clock edge. At the same edge it copies the upper HALF_W bits of the count into the holding register. `rdata_o` holds its value until the next read.
- R4: A read of offset 0x004 returns the holding register, that is the upper half captured by the latest 0x000 read, and not the live upper half.
- R5: A write to offset 0x00C only stages the upper alarm half. It neither arms the comparator nor raises an interrupt.
- R6: A write to offset 0x008 commits {staged upper half, wdata low half} as the alarm and arms it. The pending flag sets at the first edge where the count before that edge is at or above the alarm. The comparator then disarms, so each arming gives exactly one event.
- R7: If a committed alarm is already at or below the count, the pending flag sets at the edge that follows the commit edge.
- R8: A write to offset 0x014 sets the enable bit to wdata bit 0. `irq_o` is high exactly when both the pending flag and the enable bit are set. A read of 0x014 returns the enable bit in bit 0.
- R9: A write to offset 0x010 with wdata bit 0 = 1 clears the pending flag. With bit 0 = 0 the write has no effect.
- R10: If a clear write and an alarm hit fall on the same edge, the pending flag ends up set, so the event is not lost.
- R11: Reads of offsets 0x008, 0x00C, 0x010 and of every unmapped offset return zero. Writes to 0x000, 0x004 and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one count step per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (12) | Byte offset inside the 4 KiB register window |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W (32) | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | DATA_W (32) | Read data, valid the clock after the read strobe |
| irq_o | output | 1 | Level interrupt: pending AND enable |

## Verification
The alarm hit that sets the pending flag and a software clear write can land on the same clock edge. The bench provokes this by arming an alarm at a known count and issuing the clear write exactly on the edge where the count reaches the alarm. It judges the result by `irq_o` going high and staying high after that edge, and by a second clear removing it. The carry between the count halves is reached within the run by building the bench with an 8-bit half, so the holding register can be seen keeping an old upper half while the live one moves on.

// File: rtl/timer_regs_pkg.sv
package timer_regs_pkg;
  localparam int unsigned REG_ADDR_W = 12;
  localparam logic [REG_ADDR_W-1:0] OFF_TIME_LO  = 12'h000;
  localparam logic [REG_ADDR_W-1:0] OFF_TIME_HI  = 12'h004;
  localparam logic [REG_ADDR_W-1:0] OFF_ALARM_LO = 12'h008;
  localparam logic [REG_ADDR_W-1:0] OFF_ALARM_HI = 12'h00C;
  localparam logic [REG_ADDR_W-1:0] OFF_CLEAR    = 12'h010;
  localparam logic [REG_ADDR_W-1:0] OFF_IRQ_EN   = 12'h014;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TIME_LO, SEL_TIME_HI, SEL_ALARM_LO,
    SEL_ALARM_HI, SEL_CLEAR, SEL_IRQ_EN
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [REG_ADDR_W-1:0] a);
    case (a)
      OFF_TIME_LO:  return SEL_TIME_LO;
      OFF_TIME_HI:  return SEL_TIME_HI;
      OFF_ALARM_LO: return SEL_ALARM_LO;
      OFF_ALARM_HI: return SEL_ALARM_HI;
      OFF_CLEAR:    return SEL_CLEAR;
      OFF_IRQ_EN:   return SEL_IRQ_EN;
      default:      return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] StepV = CNT_W'(STEP);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + StepV;
  end

  assign count_o = count_q;

  // R2: one step per edge
  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> count_q == CNT_W'($past(count_q) + StepV));
endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [HALF_W-1:0] live_hi_i,
  output logic [HALF_W-1:0] hold_o
);
  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= live_hi_i;
  end

  assign hold_o = hold_q;

  // R3: capture on low read
  a_r3_capture_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> hold_q == $past(live_hi_i));
  // R4: holding register frozen between low reads
  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(hold_q));
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_we_i,
  input  logic              commit_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              hit_o
);
  logic [HALF_W-1:0] stage_q;
  logic [CNT_W-1:0]  alarm_q;
  logic              armed_q;
  logic              hit;

  assign hit = armed_q && (count_i >= alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      alarm_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (stage_we_i) stage_q <= wdata_i;
      if (commit_we_i) begin
        alarm_q <= {stage_q, wdata_i};
        armed_q <= 1'b1;
      end else if (hit) begin
        armed_q <= 1'b0;  // one event per arming
      end
    end
  end

  assign hit_o = hit;

  // R6: low write commits and arms
  a_r6_commit_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_we_i |=> armed_q && alarm_q[HALF_W-1:0] == $past(wdata_i));
  // R6: disarm only through a hit
  a_r6_disarm_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> $past(hit));
  // R5: staging write leaves armed state alone
  a_r5_stage_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_we_i && !armed_q) |=> !armed_q);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic en_o,
  output logic irq_o
);
  logic pend_q;
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (hit_i)      pend_q <= 1'b1;  // set wins over clear
      else if (clr_i) pend_q <= 1'b0;
      if (en_we_i) en_q <= en_d_i;
    end
  end

  assign en_o  = en_q;
  assign irq_o = pend_q & en_q;

  // R6: every hit leaves the flag set
  a_r6_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> pend_q);
  // R10: flag sets only through a hit
  a_r10_rise_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(hit_i));
  // R9: clear without hit drops the flag
  a_r9_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !pend_q);
endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
  import timer_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_ADDR_W,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned STEP   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  count;
  logic [HALF_W-1:0] hold_hi;
  logic              hit, en;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign sel = decode_off(REG_ADDR_W'(addr_i));

  tmr_counter #(.CNT_W(CNT_W), .STEP(STEP)) u_cnt (
    .clk_i, .rst_ni, .count_o(count)
  );

  tmr_snapshot #(.HALF_W(HALF_W)) u_snap (
    .clk_i, .rst_ni,
    .cap_i     (rd_en_i && sel == SEL_TIME_LO),
    .live_hi_i (count[CNT_W-1:HALF_W]),
    .hold_o    (hold_hi)
  );

  tmr_alarm #(.HALF_W(HALF_W)) u_alarm (
    .clk_i, .rst_ni,
    .stage_we_i  (wr_en_i && sel == SEL_ALARM_HI),
    .commit_we_i (wr_en_i && sel == SEL_ALARM_LO),
    .wdata_i     (wdata_i[HALF_W-1:0]),
    .count_i     (count),
    .hit_o       (hit)
  );

  tmr_irq u_irq (
    .clk_i, .rst_ni,
    .hit_i   (hit),
    .clr_i   (wr_en_i && sel == SEL_CLEAR && wdata_i[0]),
    .en_we_i (wr_en_i && sel == SEL_IRQ_EN),
    .en_d_i  (wdata_i[0]),
    .en_o    (en),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_TIME_LO: rd_mux[HALF_W-1:0] = count[HALF_W-1:0];
      SEL_TIME_HI: rd_mux[HALF_W-1:0] = hold_hi;
      SEL_IRQ_EN:  rd_mux[0]          = en;
      default:     rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R11: write-only and unmapped offsets read as zero
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel != SEL_TIME_LO && sel != SEL_TIME_HI && sel != SEL_IRQ_EN)
    |=> rdata_o == '0);
  // R3: read data held between reads
  a_r3_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_alarm_timer.sv
`timescale 1ns/1ps
module tb_alarm_timer;
  localparam int HW = 8;
  localparam logic [11:0] T_LO = 12'h000, T_HI = 12'h004, A_LO = 12'h008,
                          A_HI = 12'h00C, CLR = 12'h010, IEN = 12'h014;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  int unsigned mdl = 0;  // expected count

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mdl <= 0; else mdl <= (mdl + 1) & 32'hFFFF;

  alarm_timer #(.HALF_W(HW)) dut (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rd_en_i, .rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output int unsigned c);
    addr_i = a; rd_en_i = 1'b1; c = mdl;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic wait_irq(output int unsigned at);
    at = 32'hFFFF_FFFF;
    for (int i = 0; i < 200; i++) begin
      if (irq_o) begin at = mdl; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic arm(input int unsigned a);
    wr(A_HI, {24'h0, a[15:8]});
    wr(A_LO, {24'hABCDEF, a[7:0]});
  endtask

  task automatic t_reset;
    logic [31:0] d; int unsigned c;
    chk("R1 irq", {31'h0, irq_o}, 0);
    chk("R1 rdata", rdata_o, 0);
    rd(T_HI, d, c); chk("R1 hold", d, 0);
    rd(IEN, d, c);  chk("R1 enable", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d; int unsigned c1, c2;
    rd(T_LO, d, c1); chk("R3 low read", d, c1 & 8'hFF);
    repeat (7) @(negedge clk_i);
    rd(T_LO, d, c2); chk("R2 step", d, c2 & 8'hFF);
    chk("R2 delta", c2 - c1, 8);
    repeat (3) @(negedge clk_i);
    chk("R3 rdata held", rdata_o, c2 & 8'hFF);
  endtask

  task automatic t_hold;
    logic [31:0] d; int unsigned c;
    while ((mdl & 8'hFF) != 8'hF0) @(negedge clk_i);
    rd(T_LO, d, c); chk("R3 low", d, c & 8'hFF);
    repeat (40) @(negedge clk_i);  // carry into upper half
    rd(T_HI, d, c); chk("R4 stale hi", d, ((c - 41) >> 8) & 8'hFF);
    rd(T_LO, d, c);
    rd(T_HI, d, c); chk("R4 fresh hi", d, ((c - 1) >> 8) & 8'hFF);
  endtask

  task automatic t_stage;
    wr(IEN, 1);
    wr(A_HI, 0);  // alarm 0x00xx would be in the past if armed
    repeat (20) @(negedge clk_i);
    chk("R5 stage only", {31'h0, irq_o}, 0);
  endtask

  task automatic t_alarm;
    int unsigned a, at;
    a = mdl + 30;
    arm(a);
    chk("R6 not early", {31'h0, irq_o}, 0);
    wait_irq(at); chk("R6 hit cycle", at, a + 1);
    wr(CLR, 1); chk("R9 cleared", {31'h0, irq_o}, 0);
    repeat (40) @(negedge clk_i);
    chk("R6 one shot", {31'h0, irq_o}, 0);
  endtask

  task automatic t_past;
    int unsigned a;
    a = mdl - 5;
    arm(a);
    chk("R7 commit edge", {31'h0, irq_o}, 0);
    @(negedge clk_i);
    chk("R7 next edge", {31'h0, irq_o}, 1);
    wr(CLR, 0); chk("R9 bit0 zero", {31'h0, irq_o}, 1);
    wr(CLR, 1);
  endtask

  task automatic t_enable;
    logic [31:0] d; int unsigned a, c;
    wr(IEN, 0);
    a = mdl + 15;
    arm(a);
    while (mdl != a + 3) @(negedge clk_i);
    chk("R8 gated", {31'h0, irq_o}, 0);
    rd(IEN, d, c); chk("R8 read en", d, 0);
    wr(IEN, 32'hFFFF_FFFF);
    chk("R8 pending shown", {31'h0, irq_o}, 1);
    wr(IEN, 0); chk("R8 disable", {31'h0, irq_o}, 0);
    wr(IEN, 1); wr(CLR, 1);
  endtask

  task automatic t_collide;
    int unsigned a;
    a = mdl + 20;
    arm(a);
    while (mdl != a) @(negedge clk_i);
    wr(CLR, 1);  // same edge as the hit
    chk("R10 set wins", {31'h0, irq_o}, 1);
    wr(CLR, 1);
    chk("R10 later clear", {31'h0, irq_o}, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; int unsigned c;
    wr(T_LO, 32'h55); wr(T_HI, 32'h77); wr(12'h018, 32'h1);
    rd(T_LO, d, c); chk("R11 time write ignored", d, c & 8'hFF);
    rd(12'h018, d, c); chk("R11 unmapped", d, 0);
    rd(A_LO, d, c);    chk("R11 alarm lo reads 0", d, 0);
    rd(CLR, d, c);     chk("R11 clear reads 0", d, 0);
    rd(12'hFFC, d, c); chk("R11 top of window", d, 0);
    chk("R11 no irq", {31'h0, irq_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_count;
    t_hold;
    t_stage;
    t_alarm;
    t_past;
    t_enable;
    t_collide;
    t_unmapped;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule